// File: doc/BRIEF.md
# Dual Charge-Pump PWM Controller

This block generates the switching drives for two DC-to-DC charge pumps. Each drive is a pulse-width modulated signal. Its period is a frame of 16 slots, and each slot lasts a fixed number of master clocks (12 by default). A 12-bit control register holds three 4-bit on-time settings. Drive 0 has two of them, one for battery operation and one for mains operation, and the `on_mains` input picks between them. Drive 1 has a single setting. A setting of N makes its drive active for the first N slots of every frame. A setting of 0 holds the drive at its inactive level.

The active sense of each drive is not programmed. While power-on reset is asserted, the block samples the level present on each drive pin. When that reset is released, the sampled level is kept as the drive's idle level: a low pin gives an active-high drive, and a high pin gives an active-low drive. A system reset clears the register and the frame timing but leaves the sampled polarity unchanged. A new setting, or a change of power source, is loaded only at a frame boundary, so a frame is never cut short or stretched.

Top module: `pump_pwm`

## Requirements
- R1: The control register is 12 bits wide. A write with `wr_en` high appears on `rd_data` after the next clock edge. Both system reset (`rst_n` low) and power-on reset (`por_n` low) clear it to zero.
- R2: Register field positions: bits [3:0] hold the drive-0 setting for battery power, bits [7:4] hold the drive-0 setting for mains power, and bits [11:8] hold the drive-1 setting.
- R3: An active setting of 0 keeps the drive at its inactive level for the whole frame.
- R4: An active setting N (1..15) makes the drive active for exactly N*12 of every 192 master clocks. Each slot lasts 12 clocks and a frame has 16 slots.
- R5: The active part of each frame starts at slot 0 and ends after slot N-1. The first frame boundary is the 192nd rising edge after both resets are released.
- R6: With `on_mains` = 1, drive 0 uses bits [7:4]; with `on_mains` = 0 it uses bits [3:0]. Drive 1 uses bits [11:8] whatever the value of `on_mains`.
- R7: A register write or a change of `on_mains` affects the drives only from the next frame boundary on. After either reset, the active settings are zero until the first frame boundary.
- R8: Each drive's polarity is captured separately from `pin_sense` while `por_n` is low. A captured 0 makes that drive active high, and a captured 1 makes it active low.
- R9: System reset and any change on `pin_sense` while `por_n` is high leave the captured polarity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; also samples `pin_sense` |
| rst_n | input | 1 | System reset, active low, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 12 | Register write data |
| rd_data | output | 12 | Register contents |
| on_mains | input | 1 | Power source: 1 = mains, 0 = battery |
| pin_sense | input | 2 | Drive pin levels observed during power-on reset, one bit per drive |
| drv_out | output | 2 | Pump drives; bit 0 is drive 0, bit 1 is drive 1 |

## Verification
Every setting from 0 to 15 is swept on both power sources and under two opposite polarity pairs. The unselected drive-0 field always holds a different value, so a wrong field choice changes the active-clock count. For each frame the bench compares the count of active clocks and the slot-by-slot shape. This separates a wrong slot length, a wrong comparison edge and a frame that does not start at slot 0. Separate scenarios cover three more points. Changing the source and writing the register in mid-frame must leave the rest of that frame unchanged. The first frame after reset must stay idle. The polarity must survive a system reset while the pin levels change.

// File: rtl/pump_pwm.sv
module pump_pwm #(
  parameter int PRESCALE = 12,
  parameter int FIELD_W  = 4
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [3*FIELD_W-1:0]   wr_data,
  output logic [3*FIELD_W-1:0]   rd_data,
  input  logic                   on_mains,
  input  logic [1:0]             pin_sense,
  output logic [1:0]             drv_out
);
  localparam int REG_W = 3 * FIELD_W;
  localparam int PS_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic                        sys_rst;
  logic [REG_W-1:0]            ctrl;
  logic [PS_W-1:0]             pre;
  logic                        tick;
  logic [FIELD_W-1:0]          slot;
  logic                        frame_end;
  logic [1:0][FIELD_W-1:0]     nxt_duty;
  logic [1:0][FIELD_W-1:0]     act_duty;
  logic [1:0]                  pol;

  assign sys_rst = !rst_n || !por_n;

  always_ff @(posedge clk)
    if (sys_rst)    ctrl <= '0;
    else if (wr_en) ctrl <= wr_data;

  assign rd_data = ctrl;

  assign tick = (pre == PS_W'(PRESCALE - 1));

  always_ff @(posedge clk)
    if (sys_rst || tick) pre <= '0;
    else                 pre <= pre + 1'b1;

  always_ff @(posedge clk)
    if (sys_rst)   slot <= '0;
    else if (tick) slot <= slot + 1'b1;

  assign frame_end = tick && (slot == '1);

  assign nxt_duty[0] = on_mains ? ctrl[2*FIELD_W-1:FIELD_W] : ctrl[FIELD_W-1:0];
  assign nxt_duty[1] = ctrl[3*FIELD_W-1:2*FIELD_W];

  always_ff @(posedge clk)
    if (sys_rst)        act_duty <= '0;
    else if (frame_end) act_duty <= nxt_duty;

  always_ff @(posedge clk)
    if (!por_n) pol <= pin_sense;

  for (genvar i = 0; i < 2; i++) begin : g_drv
    assign drv_out[i] = (slot < act_duty[i]) ^ pol[i];

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (sys_rst)
      (act_duty[i] == '0) |-> (drv_out[i] == pol[i]));

    p_duty_hold_r7: assert property (@(posedge clk) disable iff (sys_rst)
      !frame_end |=> $stable(act_duty[i]));

    p_pol_keep_r9: assert property (@(posedge clk) disable iff (!por_n)
      por_n |=> $stable(pol[i]));
  end

  p_reg_clear_r1: assert property (@(posedge clk)
    sys_rst |=> (rd_data == '0));

  p_reg_write_r1: assert property (@(posedge clk) disable iff (sys_rst)
    wr_en |=> (rd_data == $past(wr_data)));

  p_slot_len_r4: assert property (@(posedge clk) disable iff (sys_rst)
    tick |=> (pre == '0));

  p_frame_wrap_r5: assert property (@(posedge clk) disable iff (sys_rst)
    frame_end |=> (slot == '0));
endmodule

// File: tb/tb_pump_pwm.sv
module tb_pump_pwm;
  localparam int FRAME = 192;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_data = '0;
  logic [11:0] rd_data;
  logic        on_mains = 1'b0;
  logic [1:0]  pin_sense = 2'b00;
  logic [1:0]  drv_out;
  logic [1:0]  exp_pol = 2'b00;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  pump_pwm dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .on_mains(on_mains),
    .pin_sense(pin_sense), .drv_out(drv_out)
  );

  always #5 clk = ~clk;

  always @(posedge clk)
    if (!por_n || !rst_n) cyc <= 0;
    else                  cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_por(input logic [1:0] pins);
    pin_sense = pins;
    exp_pol   = pins;
    por_n = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
  endtask

  task automatic wait_pos(input int p);
    do @(negedge clk); while ((cyc % FRAME) != p);
  endtask

  task automatic wr_mid(input logic [11:0] d, input logic src);
    wait_pos(95);
    wr_data  = d;
    on_mains = src;
    wr_en    = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(rd_data == d, "R1", "register readback", int'(rd_data), int'(d));
  endtask

  task automatic measure(input int n0, input int n1, input string tag0,
                         input string tag1);
    int c0 = 0, c1 = 0, bad0 = 0, bad1 = 0;
    wait_pos(0);
    for (int k = 0; k < FRAME; k++) begin
      bit a0, a1;
      a0 = drv_out[0] ^ exp_pol[0];
      a1 = drv_out[1] ^ exp_pol[1];
      if (a0) c0++;
      if (a1) c1++;
      if (a0 != ((k / 12) < n0)) bad0++;
      if (a1 != ((k / 12) < n1)) bad1++;
      if (k < FRAME - 1) @(negedge clk);
    end
    chk(c0 == n0 * 12, tag0, "drive0 active clocks per frame", c0, n0 * 12);
    chk(c1 == n1 * 12, tag1, "drive1 active clocks per frame", c1, n1 * 12);
    chk(bad0 == 0, "R5", "drive0 slot alignment mismatches", bad0, 0);
    chk(bad1 == 0, "R5", "drive1 slot alignment mismatches", bad1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not complete", 0, 1);
    finish_run();
  end

  initial begin
    // R8: reset state and captured idle levels
    do_por(2'b10);
    @(negedge clk);
    chk(rd_data == 12'h000, "R1", "register after power-on reset", int'(rd_data), 0);
    chk(drv_out == 2'b10, "R8", "idle levels after power-on reset", int'(drv_out), 2);

    // R9: system reset with changed pins keeps polarity
    pin_sense = 2'b01;
    wr_data = 12'h5A5; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 12'h000, "R1", "register after system reset", int'(rd_data), 0);
    chk(drv_out == 2'b10, "R9", "idle levels after system reset", int'(drv_out), 2);
    wr_mid(12'h604, 1'b0);
    measure(4, 6, "R9", "R9");

    // R5/R7: first frame after reset stays idle, then starts at slot 0
    do_por(2'b00);
    wr_data = 12'h008; on_mains = 1'b0; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    while (cyc != 191) @(negedge clk);
    chk(drv_out[0] == 1'b0, "R7", "drive0 before first boundary", drv_out[0], 0);
    @(negedge clk);
    chk(drv_out[0] == 1'b1, "R5", "drive0 at first frame start", drv_out[0], 1);
    while (cyc != 287) @(negedge clk);
    chk(drv_out[0] == 1'b1, "R4", "drive0 last active clock", drv_out[0], 1);
    @(negedge clk);
    chk(drv_out[0] == 1'b0, "R4", "drive0 first idle clock", drv_out[0], 0);

    // R7: mid-frame source change and write do not alter the current frame
    wr_mid(12'h2C3, 1'b0);
    wait_pos(0);
    wait_pos(95);
    on_mains = 1'b1;
    wr_data = 12'hAC3; wr_en = 1'b1;
    begin
      int bad = 0;
      for (int k = 96; k < FRAME; k++) begin
        @(negedge clk);
        wr_en = 1'b0;
        if (drv_out != 2'b00) bad++;
      end
      chk(bad == 0, "R7", "mid-frame change leaked into frame", bad, 0);
    end
    measure(12, 10, "R6", "R7");

    // R2/R3/R4/R6/R8: sweep every setting, both sources, two polarity pairs
    for (int pp = 0; pp < 2; pp++) begin
      do_por(pp == 0 ? 2'b01 : 2'b10);
      for (int src = 0; src < 2; src++) begin
        for (int n = 0; n < 16; n++) begin
          logic [3:0] other, d1;
          logic [11:0] word;
          other = 4'(15 - n);
          d1    = 4'((n + 5) % 16);
          word  = (src == 1) ? {d1, 4'(n), other} : {d1, other, 4'(n)};
          wr_mid(word, src[0]);
          measure(n, int'(d1), (n == 0) ? "R3" : (src == 1 ? "R6" : "R2"),
                  (d1 == 0) ? "R3" : "R4");
        end
      end
    end

    finish_run();
  end
endmodule